// File: doc/BRIEF.md
# SPI Pin-Mode Control Unit

This block sits beside the shift engine of an SPI port that can run as master or as slave. It holds one small control register and turns the fields in it into pin behaviour. From those fields, the role input and the wait-mode input it decides three things. First, which of the two data pads the port drives or listens on, and whether the select pad belongs to the port. Second, whether the engine must be told to drop the current transfer. Third, whether the baud generator may keep running.

There are two wiring modes. In the normal two-wire mode the master sends on MOSI and listens on MISO, and the slave does the reverse. In the single-wire mode each role uses one pad for both directions: the master uses MOSI and the slave uses MISO. A register field then opens or closes that pad's output buffer. While the buffer is open, the bit being sent is also fed back as the received bit. While it is closed, the pad is read. If the master rewrites the wiring mode, or changes the buffer enable while single-wire mode is selected, the shift engine gets a one-cycle abort request.

Top module: `spi_pinmode_ctrl`

## Requirements
- R1: After synchronous reset the control register reads 0x00, the abort request is low and the clock enable is high.
- R2: The register fields are: select-pin use enable at bit 4, single-wire buffer enable at bit 3, wait-stop at bit 1 and single-wire mode at bit 0. Bits 7, 6, 5 and 2 always read 0, and writing 1 to them changes nothing. A write of 0xFF reads back as 0x1B.
- R3: With single-wire mode at 0 and the role as master, MOSI is driven with the transmit bit, MISO is not driven, and the received bit is the MISO pad.
- R4: With single-wire mode at 0 and the role as slave, MISO is driven with the transmit bit, MOSI is not driven, and the received bit is the MOSI pad.
- R5: With single-wire mode at 1 and the role as master, MISO is never driven. The MOSI enable follows the buffer enable. The received bit is the transmit bit when the buffer is open, and the MOSI pad when it is closed.
- R6: With single-wire mode at 1 and the role as slave, MOSI is never driven. The MISO enable follows the buffer enable. The received bit is the transmit bit when the buffer is open, and the MISO pad when it is closed.
- R7: A write in master role that changes the single-wire mode bit raises the abort request for exactly the one cycle after the write edge.
- R8: A write in master role that changes the buffer enable while the written value has single-wire mode at 1 also raises the one-cycle abort.
- R9: No abort is raised by a write in slave role. No abort is raised by a master write that leaves those bits unchanged. No abort is raised by a buffer-enable change while single-wire mode is 0.
- R10: The select pad is claimed as an input by the port whenever the role is slave. In master role it is claimed only while the select-pin use enable is 1.
- R11: The clock enable is low exactly when wait-stop is 1 and the wait input is high, in either role.
- R12: A pad output that is not enabled is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| wait_mode | input | 1 | System wait state |
| tx_bit | input | 1 | Serial bit from the shift engine |
| rx_bit | output | 1 | Serial bit to the shift engine |
| mosi_in | input | 1 | MOSI pad input |
| mosi_out | output | 1 | MOSI pad output value |
| mosi_oe | output | 1 | MOSI pad output enable |
| miso_in | input | 1 | MISO pad input |
| miso_out | output | 1 | MISO pad output value |
| miso_oe | output | 1 | MISO pad output enable |
| ss_used | output | 1 | Select pad is owned by the port as an input |
| abort_req | output | 1 | One-cycle request to drop the transfer and go idle |
| clk_en | output | 1 | Enable for baud clock generation |

## Verification
The hardest case to reach is the abort rule. It depends on the role at the write, on the old register value and on the new one together. A change of the buffer enable must abort only when the new value selects single-wire mode. To cover it, the stimulus first writes a known value and then walks through chosen pairs of writes in master role: mode toggles, buffer toggles in each wiring mode, and repeated identical writes. It repeats a mode toggle in slave role. The abort line is sampled in the cycle after each write edge and again one cycle later.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

    localparam int REG_W      = 8;
    localparam int BIT_SSUSE  = 4;
    localparam int BIT_BUFEN  = 3;
    localparam int BIT_WSTOP  = 1;
    localparam int BIT_ONEW   = 0;

    localparam logic [REG_W-1:0] LIVE_MASK =
        REG_W'((1 << BIT_SSUSE) | (1 << BIT_BUFEN) | (1 << BIT_WSTOP) | (1 << BIT_ONEW));

    typedef struct packed {
        logic ss_use;
        logic buf_en;
        logic wait_stop;
        logic one_wire;
    } ctrl_t;

    typedef enum logic [1:0] {
        PR_MASTER_2W = 2'b00,
        PR_SLAVE_2W  = 2'b01,
        PR_MASTER_1W = 2'b10,
        PR_SLAVE_1W  = 2'b11
    } pin_role_e;

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] v);
        ctrl_t c;
        c.ss_use    = v[BIT_SSUSE];
        c.buf_en    = v[BIT_BUFEN];
        c.wait_stop = v[BIT_WSTOP];
        c.one_wire  = v[BIT_ONEW];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] v;
        v            = '0;
        v[BIT_SSUSE] = c.ss_use;
        v[BIT_BUFEN] = c.buf_en;
        v[BIT_WSTOP] = c.wait_stop;
        v[BIT_ONEW]  = c.one_wire;
        return v;
    endfunction

    function automatic pin_role_e role_of(input logic master, input logic one_wire);
        return pin_role_e'({one_wire, ~master});
    endfunction

endpackage

// File: rtl/spi_pm_regs.sv
module spi_pm_regs
    import spi_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             is_master,
    output ctrl_t            ctrl,
    output logic             abort_req
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_nx;
    logic  reconfig;

    assign ctrl_nx = unpack_ctrl(wr_data);

    // mode flip, or buffer flip when the new setting is single-wire
    assign reconfig = (ctrl_nx.one_wire ^ ctrl_q.one_wire)
                    | (ctrl_nx.one_wire & (ctrl_nx.buf_en ^ ctrl_q.buf_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            abort_req <= 1'b0;
        end else begin
            abort_req <= wr_en & is_master & reconfig;
            if (wr_en) begin
                ctrl_q <= ctrl_nx;
            end
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/spi_pm_steer.sv
module spi_pm_steer
    import spi_pm_pkg::*;
#(
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  ctrl_t ctrl,
    input  logic  is_master,
    input  logic  tx_bit,
    input  logic  mosi_in,
    input  logic  miso_in,
    output logic  mosi_out,
    output logic  mosi_oe,
    output logic  miso_out,
    output logic  miso_oe,
    output logic  rx_bit,
    output logic  ss_used
);
    pin_role_e role;
    logic      loop_bit;

    assign role     = role_of(is_master, ctrl.one_wire);
    assign loop_bit = tx_bit;

    always_comb begin
        mosi_oe = 1'b0;
        miso_oe = 1'b0;
        rx_bit  = 1'b0;
        unique case (role)
            PR_MASTER_2W: begin
                mosi_oe = 1'b1;
                rx_bit  = miso_in;
            end
            PR_SLAVE_2W: begin
                miso_oe = 1'b1;
                rx_bit  = mosi_in;
            end
            PR_MASTER_1W: begin
                mosi_oe = ctrl.buf_en;
                rx_bit  = ctrl.buf_en ? loop_bit : mosi_in;
            end
            PR_SLAVE_1W: begin
                miso_oe = ctrl.buf_en;
                rx_bit  = ctrl.buf_en ? loop_bit : miso_in;
            end
            default: ;
        endcase
    end

    assign mosi_out = mosi_oe ? tx_bit : IDLE_LEVEL;
    assign miso_out = miso_oe ? tx_bit : IDLE_LEVEL;
    assign ss_used  = ~is_master | ctrl.ss_use;
endmodule

// File: rtl/spi_pm_clkgate.sv
module spi_pm_clkgate
    import spi_pm_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  wait_mode,
    output logic  clk_en
);
    // only the internal baud enable is gated; an external serial clock is untouched
    assign clk_en = ~(ctrl.wait_stop & wait_mode);
endmodule

// File: rtl/spi_pinmode_ctrl.sv
module spi_pinmode_ctrl
    import spi_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             is_master,
    input  logic             wait_mode,
    input  logic             tx_bit,
    output logic             rx_bit,
    input  logic             mosi_in,
    output logic             mosi_out,
    output logic             mosi_oe,
    input  logic             miso_in,
    output logic             miso_out,
    output logic             miso_oe,
    output logic             ss_used,
    output logic             abort_req,
    output logic             clk_en
);
    ctrl_t ctrl;

    spi_pm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .is_master (is_master),
        .ctrl      (ctrl),
        .abort_req (abort_req)
    );

    spi_pm_steer #(.IDLE_LEVEL(1'b0)) u_steer (
        .ctrl      (ctrl),
        .is_master (is_master),
        .tx_bit    (tx_bit),
        .mosi_in   (mosi_in),
        .miso_in   (miso_in),
        .mosi_out  (mosi_out),
        .mosi_oe   (mosi_oe),
        .miso_out  (miso_out),
        .miso_oe   (miso_oe),
        .rx_bit    (rx_bit),
        .ss_used   (ss_used)
    );

    spi_pm_clkgate u_gate (
        .ctrl      (ctrl),
        .wait_mode (wait_mode),
        .clk_en    (clk_en)
    );

    assign rd_data = pack_ctrl(ctrl);
endmodule

// File: rtl/spi_pm_chk.sv
module spi_pm_chk
    import spi_pm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             is_master,
    input logic             wait_mode,
    input logic             mosi_oe,
    input logic             miso_oe,
    input logic             ss_used,
    input logic             abort_req,
    input logic             clk_en
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

    // R5
    single_driver_chk: assert property (@(posedge clk) disable iff (rst)
        !(mosi_oe && miso_oe));

    // R7
    mode_flip_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_master && (wr_data[BIT_ONEW] != rd_data[BIT_ONEW])) |=> abort_req);

    // R9
    abort_source_chk: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> $past(wr_en && is_master));

    // R10
    slave_ss_chk: assert property (@(posedge clk) disable iff (rst)
        !is_master |-> ss_used);

    // R11
    wait_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wait_mode && rd_data[BIT_WSTOP]) |-> !clk_en);
endmodule

bind spi_pinmode_ctrl spi_pm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .is_master (is_master),
    .wait_mode (wait_mode),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .ss_used   (ss_used),
    .abort_req (abort_req),
    .clk_en    (clk_en)
);

// File: tb/sim_spi_pinmode_ctrl.sv
`timescale 1ns/1ps
module sim_spi_pinmode_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       is_master, wait_mode, tx_bit, mosi_in, miso_in;
    logic       rx_bit, mosi_out, mosi_oe, miso_out, miso_oe;
    logic       ss_used, abort_req, clk_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    spi_pinmode_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .is_master(is_master), .wait_mode(wait_mode), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_used(ss_used), .abort_req(abort_req), .clk_en(clk_en)
    );

    // reg, master, wait, tx, mosi_in, miso_in,
    // expected {mosi_oe, mosi_out, miso_oe, miso_out, rx, ss_used, clk_en}
    typedef struct packed {
        logic [7:0] regv;
        logic       m, w, tx, mi, so;
        logic [6:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 7'b1100101}, // R3
        '{8'h10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7'b0011111}, // R4
        '{8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 7'b0000001}, // R5 closed, R12
        '{8'h09, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 7'b1100101}, // R5 open loopback
        '{8'h19, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0010011}, // R6 open loopback
        '{8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 7'b0000111}, // R6 closed
        '{8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 7'b1000010}, // R11 master, R10
        '{8'h02, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'b0011010}, // R11 slave
        '{8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 7'b1000001}  // R11 no wait, R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // write, then check abort in the cycle after the edge and once more after
    task automatic abort_case(input string req, input logic [7:0] v, input logic exp);
        write_reg(v);
        check(req, {31'b0, abort_req}, {31'b0, exp});
        @(negedge clk);
        check({req, " pulse width"}, {31'b0, abort_req}, 32'b0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        is_master = 1'b1; wait_mode = 1'b1; tx_bit = 1'b0; mosi_in = 1'b0; miso_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reg", {24'b0, rd_data}, 32'h00);
        check("R1 abort", {31'b0, abort_req}, 32'b0);
        check("R1 clk_en", {31'b0, clk_en}, 32'b1);

        write_reg(8'hFF);
        check("R2 readback", {24'b0, rd_data}, 32'h1B);
        write_reg(8'hE4);
        check("R2 reserved ignored", {24'b0, rd_data}, 32'h00);

        for (int i = 0; i < NV; i++) begin
            is_master = 1'b0;
            write_reg(VT[i].regv);
            is_master = VT[i].m;  wait_mode = VT[i].w; tx_bit = VT[i].tx;
            mosi_in   = VT[i].mi; miso_in   = VT[i].so;
            @(negedge clk);
            check("R2 table reg", {24'b0, rd_data}, {24'b0, VT[i].regv});
            check($sformatf("R3-6 R10 R11 R12 row %0d", i),
                  {25'b0, mosi_oe, mosi_out, miso_oe, miso_out, rx_bit, ss_used, clk_en},
                  {25'b0, VT[i].exp});
        end

        // abort behaviour
        wait_mode = 1'b0;
        is_master = 1'b0;
        write_reg(8'h00);
        @(negedge clk);
        is_master = 1'b1;
        abort_case("R7 mode 0->1",        8'h01, 1'b1);
        abort_case("R9 same value",       8'h01, 1'b0);
        abort_case("R8 buf flip in 1w",   8'h09, 1'b1);
        abort_case("R9 ss_use only",      8'h19, 1'b0);
        abort_case("R7 mode 1->0",        8'h10, 1'b0 | 1'b1);
        abort_case("R9 buf flip in 2w",   8'h18, 1'b0);
        abort_case("R9 wait_stop only",   8'h1A, 1'b0);
        is_master = 1'b0;
        abort_case("R9 slave mode flip",  8'h1B, 1'b0);
        abort_case("R9 slave buf flip",   8'h13, 1'b0);
        check("R10 slave ss with ss_use", {31'b0, ss_used}, 32'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule